// File: doc/BRIEF.md
# Standby Wake and Supply Control

This block lives in the always-on standby domain and decides when the system may power up. It filters the active-low power button, which is slow and bouncy, against a slow 32.768 kHz tick. It mirrors the filtered button level onto an active-low button line toward the chipset. It also watches the telephone ring line for a burst of pulses. Either source can latch a sticky wake status bit. Any status bit whose enable is set pulls the active-low power-up request low.

The same block samples the two sleep-state inputs that the ACPI controller drives. From them it controls the power-supply-on pin. A strap chooses the pin's polarity. When the strap selects active-high, the pin is push-pull. When it selects active-low, the pin is open-drain: it is driven low only while active and otherwise released. All asynchronous inputs pass through a two-stage synchronizer.

The block contains three state machines:

- **Button filter.**
  - States: `DB_REL` (released), `DB_REL_CHK` (released but seeing a low level), `DB_PRS` (pressed) and `DB_PRS_CHK` (pressed but seeing a high level).
  - Transitions: REL→REL_CHK on a low input, REL_CHK→REL on a high input, REL_CHK→PRS after the last stable tick, PRS→PRS_CHK on a high input, PRS_CHK→PRS on a low input, and PRS_CHK→REL after the last stable tick.
- **Ring detector.**
  - States: `RG_IDLE` and `RG_TRAIN`.
  - Transitions: IDLE→TRAIN on a rising edge that does not yet complete a burst, TRAIN→IDLE when the burst completes, and TRAIN→IDLE when the gap timeout expires.
- **Supply controller.**
  - States: `PS_WORK`, `PS_S3` and `PS_S45`.
  - Transitions: any state moves to PS_S45 while the S4/S5 input is asserted. Otherwise it moves to PS_S3 while the S3–S5 input is asserted, and otherwise to PS_WORK.

Top module: `stby_wake_ctrl`

## Requirements
- R1: A new button level is accepted only after `DEB_TICKS` (default 525) consecutive ticks at that level; a return to the accepted level before then discards the count, and the accepted level changes only in a cycle that follows a tick.
- R2: `btn_out_n` is 0 exactly while the accepted button level is pressed.
- R3: A ring wake event occurs when `cfg_ring_edges` (4 in normal use) rising edges arrive with each gap at most `cfg_ring_gap`+1 clock cycles; a setting of 0 or 1 makes every rising edge an event.
- R4: If no rising edge arrives within `cfg_ring_gap`+1 cycles of the previous one, the edge count restarts from zero and no event results from the earlier edges.
- R5: `wake_sts` bit 0 is set by an accepted button press and bit 1 by a ring event; set bits stay set until a write with `sts_clr_wr` high and a 1 in that bit position of `sts_clr_data`; an event in the same cycle wins over the clear.
- R6: `pwr_req_n` is 0 exactly when some bit is set in both `wake_sts` and the enable register; the enable register is loaded from `en_wdata` (bit 0 button, bit 1 ring) when `en_wr` is high.
- R7: The supply is active exactly when both `slp_s3_n` and `slp_s45_n` are high (working state); otherwise it is inactive.
- R8: With `strap_pol_hi`=1, `psu_on_out` equals the active flag and `psu_on_oe` is always 1; with `strap_pol_hi`=0, active gives `psu_on_out`=0 with `psu_on_oe`=1, and inactive gives `psu_on_out`=1 with `psu_on_oe`=0.
- R9: While reset is applied, `wake_sts` and the enables are 0, the button is taken as released, `btn_out_n` and `pwr_req_n` are 1, and the supply controller sits in PS_S45 (inactive).
- R10: `sleep_code` reports the sampled sleep state: 0 working, 1 for S3 (`slp_s3_n` low, `slp_s45_n` high), and 2 whenever `slp_s45_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby clock |
| rst_n | input | 1 | Active-low asynchronous standby reset |
| tick_32k | input | 1 | One-cycle pulse at the 32.768 kHz rate |
| pwr_btn_n | input | 1 | Power button, low when pressed |
| ring_in | input | 1 | Ring detect input, pulses while ringing |
| slp_s3_n | input | 1 | Low in sleep state 3, 4 or 5 |
| slp_s45_n | input | 1 | Low in sleep state 4 or 5 |
| strap_pol_hi | input | 1 | Supply-on polarity strap, 1 = active high |
| cfg_ring_edges | input | EDGE_W | Rising edges needed for a ring event |
| cfg_ring_gap | input | GAP_W | Longest allowed gap between edges, in cycles minus one |
| en_wr | input | 1 | Load the enable register |
| en_wdata | input | 2 | New enables (bit 0 button, bit 1 ring) |
| sts_clr_wr | input | 1 | Write-one-to-clear strobe for status |
| sts_clr_data | input | 2 | Status bits to clear |
| wake_sts | output | 2 | Sticky wake status |
| btn_out_n | output | 1 | Filtered button toward chipset, low when pressed |
| pwr_req_n | output | 1 | Power-up request, low when asserted |
| psu_on_out | output | 1 | Supply-on pin value |
| psu_on_oe | output | 1 | Supply-on pin drive enable |
| sleep_code | output | 2 | Sampled sleep state code |

## Verification
The inline assertions watch several rules on every cycle:
- the filtered button moves only after a tick, and its counter stays in range;
- the ring counter is empty whenever the detector is idle, and every ring event leaves the detector idle;
- status bits are sticky unless cleared, and an event always sets its bit;
- with no enables set, the request stays high;
- the supply state follows the sleep inputs one cycle later;
- push-pull mode always drives, and open-drain mode never drives high.

Only the bench scenarios can show the rest:
- the full 525-tick acceptance window, and that short bounces are discarded;
- the edge-count threshold, and the reset of a burst after a long gap;
- the masking of the request by the enables;
- the exact pin values for every strap and sleep combination.

// File: rtl/stby_wake_pkg.sv
package stby_wake_pkg;

    // Wake source indices within the status and enable vectors
    localparam int NUM_SRC  = 2;
    localparam int SRC_BTN  = 0;
    localparam int SRC_RING = 1;

    typedef enum logic [1:0] {
        DB_REL     = 2'd0,
        DB_REL_CHK = 2'd1,
        DB_PRS     = 2'd2,
        DB_PRS_CHK = 2'd3
    } db_st_e;

    typedef enum logic {
        RG_IDLE  = 1'b0,
        RG_TRAIN = 1'b1
    } rg_st_e;

    // Encoding doubles as the reported sleep code
    typedef enum logic [1:0] {
        PS_WORK = 2'd0,
        PS_S3   = 2'd1,
        PS_S45  = 2'd2
    } pwr_st_e;

endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] meta_q;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            hold_q <= RST_VAL;
        end else begin
            meta_q <= d_async;
            hold_q <= meta_q;
        end
    end

    assign q_sync = hold_q;

endmodule

// File: rtl/stby_btn_debounce.sv
module stby_btn_debounce
    import stby_wake_pkg::*;
#(
    parameter int DEB_TICKS = 525
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic btn_n,
    output logic pressed,
    output logic press_evt
);

    localparam int            CW   = $clog2(DEB_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

    db_st_e        st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= DB_REL;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DB_REL: begin
                if (!btn_n) st_d = DB_REL_CHK;
            end
            DB_REL_CHK: begin
                if (btn_n)                      st_d = DB_REL;
                else if (tick && cnt_q == LAST) st_d = DB_PRS;
            end
            DB_PRS: begin
                if (btn_n) st_d = DB_PRS_CHK;
            end
            DB_PRS_CHK: begin
                if (!btn_n)                     st_d = DB_PRS;
                else if (tick && cnt_q == LAST) st_d = DB_REL;
            end
        endcase
    end

    // Stable-tick counter: runs only while staying in a check state
    always_comb begin
        cnt_d = '0;
        if ((st_q == DB_REL_CHK || st_q == DB_PRS_CHK) && st_d == st_q)
            cnt_d = tick ? cnt_q + 1'b1 : cnt_q;
    end

    // Outputs
    always_comb begin
        pressed   = (st_q == DB_PRS) || (st_q == DB_PRS_CHK);
        press_evt = (st_q == DB_REL_CHK) && (st_d == DB_PRS);
    end

    assert_deb_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pressed != $past(pressed)) |-> $past(tick));

    assert_deb_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/stby_ring_detect.sv
module stby_ring_detect
    import stby_wake_pkg::*;
#(
    parameter int EDGE_W = 4,
    parameter int GAP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ring,
    input  logic [EDGE_W-1:0] cfg_edges,
    input  logic [GAP_W-1:0]  cfg_gap,
    output logic              ring_evt
);

    rg_st_e            st_q, st_d;
    logic [EDGE_W-1:0] ecnt_q, ecnt_d;
    logic [GAP_W-1:0]  gap_q, gap_d;
    logic              prev_q;
    logic              rise;
    logic              hit;

    assign rise = ring & ~prev_q;
    // This edge completes the burst
    assign hit  = ({1'b0, ecnt_q} + 1'b1) >= {1'b0, cfg_edges};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= RG_IDLE;
            ecnt_q <= '0;
            gap_q  <= '0;
            prev_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            ecnt_q <= ecnt_d;
            gap_q  <= gap_d;
            prev_q <= ring;
        end
    end

    // Transitions
    always_comb begin
        st_d   = st_q;
        ecnt_d = ecnt_q;
        gap_d  = gap_q;
        unique case (st_q)
            RG_IDLE: begin
                if (rise && !hit) begin
                    st_d   = RG_TRAIN;
                    ecnt_d = ecnt_q + 1'b1;
                    gap_d  = '0;
                end
            end
            RG_TRAIN: begin
                if (rise) begin
                    gap_d = '0;
                    if (hit) begin
                        st_d   = RG_IDLE;
                        ecnt_d = '0;
                    end else begin
                        ecnt_d = ecnt_q + 1'b1;
                    end
                end else if (gap_q >= cfg_gap) begin
                    st_d   = RG_IDLE;
                    ecnt_d = '0;
                    gap_d  = '0;
                end else begin
                    gap_d = gap_q + 1'b1;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        ring_evt = rise && hit;
    end

    assert_ring_idle_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RG_IDLE) |-> (ecnt_q == '0));

    assert_ring_evt_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ring_evt |=> (st_q == RG_IDLE));

endmodule

// File: rtl/stby_supply_ctrl.sv
module stby_supply_ctrl
    import stby_wake_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       s3_n,
    input  logic       s45_n,
    input  logic       pol_hi,
    output logic       psu_out,
    output logic       psu_oe,
    output logic [1:0] sleep_code
);

    pwr_st_e st_q, st_d;
    logic    on;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PS_S45;
        else        st_q <= st_d;
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PS_WORK: begin
                if (!s45_n)     st_d = PS_S45;
                else if (!s3_n) st_d = PS_S3;
            end
            PS_S3: begin
                if (!s45_n)    st_d = PS_S45;
                else if (s3_n) st_d = PS_WORK;
            end
            PS_S45: begin
                if (s45_n && s3_n) st_d = PS_WORK;
                else if (s45_n)    st_d = PS_S3;
            end
            default: st_d = PS_S45;
        endcase
    end

    // Outputs
    always_comb begin
        on         = (st_q == PS_WORK);
        psu_out    = pol_hi ? on : ~on;
        psu_oe     = pol_hi | on;
        sleep_code = st_q;
    end

    assert_psu_follow_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s3_n && s45_n) |=> (sleep_code == 2'd0));

    assert_psu_follow_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!s3_n || !s45_n) |=> (sleep_code != 2'd0));

    assert_psu_pushpull_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pol_hi |-> psu_oe);

    assert_psu_opendrain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pol_hi && psu_oe) |-> !psu_out);

endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
    import stby_wake_pkg::*;
#(
    parameter int DEB_TICKS = 525,
    parameter int EDGE_W    = 4,
    parameter int GAP_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic              pwr_btn_n,
    input  logic              ring_in,
    input  logic              slp_s3_n,
    input  logic              slp_s45_n,
    input  logic              strap_pol_hi,
    input  logic [EDGE_W-1:0] cfg_ring_edges,
    input  logic [GAP_W-1:0]  cfg_ring_gap,
    input  logic              en_wr,
    input  logic [1:0]        en_wdata,
    input  logic              sts_clr_wr,
    input  logic [1:0]        sts_clr_data,
    output logic [1:0]        wake_sts,
    output logic              btn_out_n,
    output logic              pwr_req_n,
    output logic              psu_on_out,
    output logic              psu_on_oe,
    output logic [1:0]        sleep_code
);

    // Synchronized inputs, order {s45, s3, ring, btn}
    logic [3:0] sync_q;
    logic       pressed;
    logic       press_evt;
    logic       ring_evt;

    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] sts_q;
    logic [NUM_SRC-1:0] evt;
    logic [NUM_SRC-1:0] clr_mask;

    stby_sync #(
        .W       (4),
        .RST_VAL (4'b0001)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({slp_s45_n, slp_s3_n, ring_in, pwr_btn_n}),
        .q_sync  (sync_q)
    );

    stby_btn_debounce #(
        .DEB_TICKS (DEB_TICKS)
    ) u_btn (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_32k),
        .btn_n     (sync_q[0]),
        .pressed   (pressed),
        .press_evt (press_evt)
    );

    stby_ring_detect #(
        .EDGE_W (EDGE_W),
        .GAP_W  (GAP_W)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring      (sync_q[1]),
        .cfg_edges (cfg_ring_edges),
        .cfg_gap   (cfg_ring_gap),
        .ring_evt  (ring_evt)
    );

    stby_supply_ctrl u_psu (
        .clk        (clk),
        .rst_n      (rst_n),
        .s3_n       (sync_q[2]),
        .s45_n      (sync_q[3]),
        .pol_hi     (strap_pol_hi),
        .psu_out    (psu_on_out),
        .psu_oe     (psu_on_oe),
        .sleep_code (sleep_code)
    );

    // Wake status and enables
    always_comb begin
        evt           = '0;
        evt[SRC_BTN]  = press_evt;
        evt[SRC_RING] = ring_evt;
        clr_mask      = sts_clr_wr ? sts_clr_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            sts_q <= '0;
        end else begin
            if (en_wr) en_q <= en_wdata;
            sts_q <= (sts_q & ~clr_mask) | evt;
        end
    end

    assign wake_sts  = sts_q;
    assign btn_out_n = ~pressed;
    assign pwr_req_n = ~|(sts_q & en_q);

    assert_sts_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_q & ~clr_mask) != '0) |=>
            ((sts_q & $past(sts_q & ~clr_mask)) == $past(sts_q & ~clr_mask)));

    assert_sts_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((sts_q & $past(evt)) == $past(evt)));

    assert_req_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> pwr_req_n);

endmodule

// File: tb/stby_wake_ctrl_tb.sv
module stby_wake_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_32k = 1'b0;
    logic        pwr_btn_n, ring_in, slp_s3_n, slp_s45_n, strap_pol_hi;
    logic [3:0]  cfg_ring_edges;
    logic [15:0] cfg_ring_gap;
    logic        en_wr, sts_clr_wr;
    logic [1:0]  en_wdata, sts_clr_data;
    logic [1:0]  wake_sts, sleep_code;
    logic        btn_out_n, pwr_req_n, psu_on_out, psu_on_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    stby_wake_ctrl u_dut (
        .clk (clk), .rst_n (rst_n), .tick_32k (tick_32k),
        .pwr_btn_n (pwr_btn_n), .ring_in (ring_in),
        .slp_s3_n (slp_s3_n), .slp_s45_n (slp_s45_n), .strap_pol_hi (strap_pol_hi),
        .cfg_ring_edges (cfg_ring_edges), .cfg_ring_gap (cfg_ring_gap),
        .en_wr (en_wr), .en_wdata (en_wdata),
        .sts_clr_wr (sts_clr_wr), .sts_clr_data (sts_clr_data),
        .wake_sts (wake_sts), .btn_out_n (btn_out_n), .pwr_req_n (pwr_req_n),
        .psu_on_out (psu_on_out), .psu_on_oe (psu_on_oe), .sleep_code (sleep_code)
    );

    // Tick pulse every 4 clocks, driven away from the active edge
    initial begin
        int tcnt = 0;
        forever begin
            @(negedge clk);
            tcnt++;
            tick_32k = (tcnt % 4 == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_active(bit s3, bit s45);
        return s3 && s45;
    endfunction
    function automatic bit exp_out(bit pol, bit s3, bit s45);
        return pol ? exp_active(s3, s45) : !exp_active(s3, s45);
    endfunction
    function automatic bit exp_oe(bit pol, bit s3, bit s45);
        return pol || exp_active(s3, s45);
    endfunction
    function automatic int exp_code(bit s3, bit s45);
        return !s45 ? 2 : (!s3 ? 1 : 0);
    endfunction
    function automatic bit exp_ring(int n, int need);
        return (need <= 1) ? (n >= 1) : (n >= need);
    endfunction
    function automatic bit exp_req(logic [1:0] sts, logic [1:0] en);
        return !(|(sts & en));
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic wr_en(input logic [1:0] v);
        @(negedge clk); en_wr = 1'b1; en_wdata = v;
        @(negedge clk); en_wr = 1'b0;
    endtask
    task automatic clr_sts(input logic [1:0] v);
        @(negedge clk); sts_clr_wr = 1'b1; sts_clr_data = v;
        @(negedge clk); sts_clr_wr = 1'b0;
    endtask
    task automatic ring_pulses(input int n, input int spacing);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ring_in = 1'b1;
            cyc(5);
            ring_in = 1'b0;
            cyc(spacing - 5);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all R): actual 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED);
        rst_n = 1'b0; pwr_btn_n = 1'b1; ring_in = 1'b0;
        slp_s3_n = 1'b0; slp_s45_n = 1'b0; strap_pol_hi = 1'b1;
        cfg_ring_edges = 4'd4; cfg_ring_gap = 16'd100;
        en_wr = 1'b0; en_wdata = '0; sts_clr_wr = 1'b0; sts_clr_data = '0;
        cyc(4);
        // R9 reset state
        chk(wake_sts == 2'b00, "R9 sts", wake_sts, 0);
        chk(btn_out_n == 1'b1, "R9 btn_out_n", btn_out_n, 1);
        chk(pwr_req_n == 1'b1, "R9 pwr_req_n", pwr_req_n, 1);
        chk(psu_on_out == 1'b0 && psu_on_oe == 1'b1, "R9 psu", {psu_on_out, psu_on_oe}, 1);
        chk(sleep_code == 2'd2, "R9 sleep_code", sleep_code, 2);
        rst_n = 1'b1;
        cyc(4);
        wr_en(2'b11);

        // R1 bounces shorter than the window are discarded
        for (int b = 0; b < 3; b++) begin
            int d = 50 + $urandom % 350;
            pwr_btn_n = 1'b0; cyc(d * 4);
            pwr_btn_n = 1'b1; cyc(20 + $urandom % 40);
            chk(btn_out_n == 1'b1, "R1 bounce", btn_out_n, 1);
        end
        chk(wake_sts == 2'b00, "R1 bounce sts", wake_sts, 0);

        // R1 R2 R5 R6 held press accepted
        pwr_btn_n = 1'b0; cyc(1800);
        chk(btn_out_n == 1'b1, "R1 before window", btn_out_n, 1);
        cyc(600);
        chk(btn_out_n == 1'b0, "R2 pressed", btn_out_n, 0);
        chk(wake_sts == 2'b01, "R5 button sts", wake_sts, 1);
        chk(pwr_req_n == exp_req(2'b01, 2'b11), "R6 request", pwr_req_n, 0);
        pwr_btn_n = 1'b1; cyc(2400);
        chk(btn_out_n == 1'b1, "R2 released", btn_out_n, 1);
        chk(wake_sts == 2'b01, "R5 sticky", wake_sts, 1);
        clr_sts(2'b10);
        cyc(2);
        chk(wake_sts == 2'b01, "R5 clear other bit", wake_sts, 1);
        clr_sts(2'b01);
        cyc(2);
        chk(wake_sts == 2'b00, "R5 clear", wake_sts, 0);
        chk(pwr_req_n == 1'b1, "R6 released", pwr_req_n, 1);

        // R3 ring threshold
        ring_pulses(3, 40); cyc(20);
        chk(wake_sts[1] == 1'b0, "R3 three edges", wake_sts[1], 0);
        cyc(300);
        ring_pulses(4, 40); cyc(20);
        chk(wake_sts[1] == 1'b1, "R3 four edges", wake_sts[1], 1);
        chk(pwr_req_n == 1'b0, "R6 ring request", pwr_req_n, 0);
        clr_sts(2'b10); cyc(300);

        // R4 long gap restarts the count
        ring_pulses(2, 40); cyc(300);
        ring_pulses(2, 40); cyc(20);
        chk(wake_sts[1] == 1'b0, "R4 gap restart", wake_sts[1], 0);
        cyc(300);

        // R6 enable masks the request
        wr_en(2'b01);
        ring_pulses(4, 40); cyc(20);
        chk(wake_sts[1] == 1'b1, "R6 masked sts", wake_sts[1], 1);
        chk(pwr_req_n == 1'b1, "R6 masked request", pwr_req_n, 1);
        wr_en(2'b11); cyc(1);
        chk(pwr_req_n == 1'b0, "R6 enabled request", pwr_req_n, 0);
        clr_sts(2'b10); cyc(300);

        // R3 random bursts
        for (int t = 0; t < 8; t++) begin
            int need = 1 + $urandom % 5;
            int n = 1 + $urandom % 7;
            int sp = 20 + $urandom % 60;
            cfg_ring_edges = 4'(need);
            ring_pulses(n, sp); cyc(20);
            chk(wake_sts[1] == exp_ring(n, need), "R3 random burst", wake_sts[1], exp_ring(n, need));
            chk(pwr_req_n == exp_req(wake_sts, 2'b11), "R6 random", pwr_req_n, exp_req(wake_sts, 2'b11));
            clr_sts(2'b11); cyc(300);
        end

        // R7 R8 R10 supply and sleep states
        for (int k = 0; k < 16; k++) begin
            bit pol = (k < 4) ? k[0] : 1'($urandom);
            bit s3 = (k < 4) ? k[1] : 1'($urandom);
            bit s45 = (k < 4) ? 1'b1 : 1'($urandom);
            @(negedge clk);
            strap_pol_hi = pol; slp_s3_n = s3; slp_s45_n = s45;
            cyc(6);
            chk(psu_on_out == exp_out(pol, s3, s45), "R7 psu_on_out", psu_on_out, exp_out(pol, s3, s45));
            chk(psu_on_oe == exp_oe(pol, s3, s45), "R8 psu_on_oe", psu_on_oe, exp_oe(pol, s3, s45));
            chk(int'(sleep_code) == exp_code(s3, s45), "R10 sleep_code", sleep_code, exp_code(s3, s45));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule